// File: doc/BRIEF.md
# Debug mode entry controller

This block sits beside a small processor core and decides, one event per clock, where each pending exception, interrupt or debug request goes. A per-event routing bit chooses between the ordinary interrupt path (a one-cycle take strobe with the event index) and entry into debug mode. In debug mode the core fetches every instruction from the debug port instead of memory, and it stays there until a return-from-interrupt is seen.

Events are kept in one vector, lowest index first: bit 0 is the non-maskable debug-port request, bits 1..N_BRK are the internal breakpoints, bit N_BRK+1 is the peripheral breakpoint, bit N_BRK+2 is the maskable debug-port request, and the exceptions follow. With the defaults (N_BRK=2, N_EXC=4) the exceptions are bits 5..8.

A one-cycle pulse on an event input is latched as pending and is cleared only when it is taken. The whole debug facility is switched on or off by a strap. This strap is sampled only while the synchronous reset is held low.

The controller has two states. In RUN it arbitrates among pending events. In DEBUG nothing is taken. There are two transitions:
- RUN to DEBUG: the winning event has its routing bit set and debug is enabled.
- DEBUG to RUN: `rfi_i` is high.

The reset state is DEBUG when both the strap and `boot_dbg_i` are high, and RUN otherwise.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: The enable strap is captured only while `rst_n` is low. Later changes of `dbg_en_strap_i` have no effect until the next reset.
- R2: When the captured enable is 0, no event ever sets debug mode. Every taken event produces `int_take_o`, whatever its routing bit.
- R3: When debug is enabled, the winning event enters debug mode (`dbg_enter_o`) if its `route_i` bit is 1. If the bit is 0 it produces `int_take_o`. `evt_idx_o` carries the index in the map given above.
- R4: The maskable request (bit N_BRK+2) stays pending and is not taken while `int_en_i` is 0. It is taken once `int_en_i` is 1.
- R5: When several events are pending, the lowest index is taken first. Exactly one event is taken per cycle, and the others are taken in later cycles.
- R6: `fetch_dbg_o` is 1 exactly while `dbg_mode_o` is 1.
- R7: `rfi_i` in DEBUG returns to RUN on the next edge. `rfi_i` in RUN has no effect.
- R8: When the strap is 1 and `boot_dbg_i` is 1 during reset, the core leaves reset in DEBUG. When the strap is 0, `boot_dbg_i` is ignored.
- R9: Events arriving in DEBUG raise no strobe and stay pending. They are taken after the return to RUN.
- R10: `int_take_o` and `dbg_enter_o` are single-cycle, mutually exclusive pulses. They appear on the clock edge at which the event input is first present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the strap is sampled while it is low |
| dbg_en_strap_i | input | 1 | Debug facility enable strap |
| boot_dbg_i | input | 1 | Start in debug mode out of reset (honoured only if enabled) |
| route_i | input | N_EV | Per-event routing, 1 = debug entry, 0 = interrupt |
| int_en_i | input | 1 | Core interrupt-enable bit; gates the maskable request |
| exc_i | input | N_EXC | Exception and interrupt events |
| brk_i | input | N_BRK | Internal breakpoint hits |
| nm_req_i | input | 1 | Non-maskable debug-port request |
| m_req_i | input | 1 | Maskable debug-port request |
| periph_brk_i | input | 1 | Peripheral breakpoint request |
| rfi_i | input | 1 | Return-from-interrupt indication |
| dbg_mode_o | output | 1 | Core is in debug mode |
| fetch_dbg_o | output | 1 | Fetch from the debug port instead of memory |
| dbg_enter_o | output | 1 | One-cycle pulse: debug mode entered |
| int_take_o | output | 1 | One-cycle pulse: regular interrupt taken |
| evt_idx_o | output | $clog2(N_EV) | Index of the event taken, valid with either strobe |

## Verification
A wrong state register shows on `dbg_mode_o` and `fetch_dbg_o` at once, one edge after the transition that should (or should not) have happened. If pending bits are lost, the take is missing in the cycle after a priority winner or after a return from debug. If pending bits stick, a duplicate strobe appears in the next cycle. Because each strobe follows its event by exactly one edge, each fault shows within one or two cycles of the stimulus that exposes it.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DEBUG = 1'b1
    } dbg_state_e;

    // non-maskable request, peripheral breakpoint, maskable request
    localparam int FIXED_EVENTS = 3;

endpackage

// File: rtl/dbg_evt_pending.sv
module dbg_evt_pending #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] take_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | raw_i) & ~take_i;
        end
    end

    // raw events count as pending in the cycle they arrive
    assign pend_o = pend_q | raw_i;

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i == '0) |=> (($past(pend_q) & ~pend_q) == '0)); // R9

endmodule

// File: rtl/dbg_evt_arbiter.sv
module dbg_evt_arbiter #(
    parameter  int N  = 9,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = IW'(i);
        end
    end

    assign grant_o = cand_i & (~cand_i + N'(1));
    assign any_o   = |cand_i;

    always_comb begin
        if (any_o) begin
            AST_GRANT_MATCHES_IDX: assert ($onehot(grant_o) && grant_o[idx_o]); // R5
        end
    end

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter  int N_EXC = 4,
    parameter  int N_BRK = 2,
    localparam int N_EV  = N_BRK + FIXED_EVENTS + N_EXC,
    localparam int IW    = $clog2(N_EV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_en_strap_i,
    input  logic             boot_dbg_i,
    input  logic [N_EV-1:0]  route_i,
    input  logic             int_en_i,
    input  logic [N_EXC-1:0] exc_i,
    input  logic [N_BRK-1:0] brk_i,
    input  logic             nm_req_i,
    input  logic             m_req_i,
    input  logic             periph_brk_i,
    input  logic             rfi_i,
    output logic             dbg_mode_o,
    output logic             fetch_dbg_o,
    output logic             dbg_enter_o,
    output logic             int_take_o,
    output logic [IW-1:0]    evt_idx_o
);

    localparam int MASK_BIT = N_BRK + 2;

    dbg_state_e    state_q, state_d;
    logic          en_q;
    logic [N_EV-1:0] raw_ev, pend, elig, cand, grant, take_oh;
    logic          any_ev, to_debug;
    logic [IW-1:0] win_idx;
    logic          enter_q, take_q;
    logic [IW-1:0] idx_q;

    assign raw_ev = {exc_i, m_req_i, periph_brk_i, brk_i, nm_req_i};

    // eligibility: nothing in DEBUG, maskable request needs int_en_i
    always_comb begin
        elig = (state_q == ST_RUN) ? '1 : '0;
        if (!int_en_i) elig[MASK_BIT] = 1'b0;
    end

    assign cand    = pend & elig;
    assign take_oh = any_ev ? grant : '0;

    dbg_evt_pending #(.N(N_EV)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_ev),
        .take_i (take_oh),
        .pend_o (pend)
    );

    dbg_evt_arbiter #(.N(N_EV)) u_arb (
        .cand_i  (cand),
        .any_o   (any_ev),
        .grant_o (grant),
        .idx_o   (win_idx)
    );

    assign to_debug = any_ev && en_q && route_i[win_idx];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (to_debug) state_d = ST_DEBUG;
            ST_DEBUG: if (rfi_i)    state_d = ST_RUN;
        endcase
    end

    // state register; strap captured only under reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= dbg_en_strap_i;
            state_q <= (dbg_en_strap_i && boot_dbg_i) ? ST_DEBUG : ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enter_q <= 1'b0;
            take_q  <= 1'b0;
            idx_q   <= '0;
        end else begin
            enter_q <= to_debug;
            take_q  <= any_ev && !to_debug;
            idx_q   <= win_idx;
        end
    end

    assign dbg_mode_o  = (state_q == ST_DEBUG);
    assign fetch_dbg_o = (state_q == ST_DEBUG);
    assign dbg_enter_o = enter_q;
    assign int_take_o  = take_q;
    assign evt_idx_o   = idx_q;

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(en_q)); // R1
    AST_OFF_NO_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !dbg_mode_o); // R2
    AST_ENTER_SETS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_enter_o |-> (dbg_mode_o && fetch_dbg_o)); // R6
    AST_RFI_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode_o && rfi_i) |=> !dbg_mode_o); // R7
    AST_QUIET_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode_o |=> (!int_take_o && !dbg_enter_o)); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_take_o && dbg_enter_o)); // R10
    AST_ENTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_enter_o |=> !dbg_enter_o); // R10

endmodule

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b1, boot = 1'b0;
    logic [8:0] route = '0;
    logic       int_en = 1'b1;
    logic [3:0] exc = '0;
    logic [1:0] brk = '0;
    logic       nm = 1'b0, mr = 1'b0, pb = 1'b0, rfi = 1'b0;
    logic       mode, fetch, enter, take;
    logic [3:0] idx;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbg_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_en_strap_i(strap), .boot_dbg_i(boot),
        .route_i(route), .int_en_i(int_en), .exc_i(exc), .brk_i(brk),
        .nm_req_i(nm), .m_req_i(mr), .periph_brk_i(pb), .rfi_i(rfi),
        .dbg_mode_o(mode), .fetch_dbg_o(fetch), .dbg_enter_o(enter),
        .int_take_o(take), .evt_idx_o(idx)
    );

    // {int_en, exp_enter, exp_idx, route, events}
    localparam logic [23:0] VEC [11] = '{
        {1'b1, 1'b0, 4'd0, 9'h000, 9'h001},
        {1'b1, 1'b1, 4'd0, 9'h001, 9'h001},
        {1'b1, 1'b0, 4'd1, 9'h000, 9'h002},
        {1'b1, 1'b1, 4'd2, 9'h004, 9'h004},
        {1'b1, 1'b1, 4'd3, 9'h1FF, 9'h008},
        {1'b1, 1'b0, 4'd4, 9'h000, 9'h010},
        {1'b1, 1'b0, 4'd5, 9'h000, 9'h020},
        {1'b1, 1'b1, 4'd8, 9'h100, 9'h100},
        {1'b1, 1'b0, 4'd7, 9'h100, 9'h080},
        {1'b1, 1'b1, 4'd6, 9'h040, 9'h040},
        {1'b1, 1'b1, 4'd4, 9'h010, 9'h010}
    };

    task automatic drive_ev(input logic [8:0] ev);
        nm = ev[0]; brk = ev[2:1]; pb = ev[3]; mr = ev[4]; exc = ev[8:5];
    endtask

    // compare {mode, fetch, take, enter, idx (only with a strobe)}
    task automatic expect_out(input string req, input logic e_mode, input logic e_take,
                              input logic e_enter, input logic [3:0] e_idx);
        logic [7:0] act, exp;
        act = {mode, fetch, take, enter, (take || enter) ? idx : 4'd0};
        exp = {e_mode, e_mode, e_take, e_enter, (e_take || e_enter) ? e_idx : 4'd0};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input logic s, input logic b);
        @(negedge clk);
        rst_n = 1'b0; strap = s; boot = b; drive_ev('0); rfi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic exit_debug(input string req);
        @(negedge clk); rfi = 1'b1;
        step();
        expect_out(req, 1'b0, 1'b0, 1'b0, 4'd0);
        @(negedge clk); rfi = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 R8 reset state: enabled, not booting into debug
        do_reset(1'b1, 1'b0);
        expect_out("R8", 1'b0, 1'b0, 1'b0, 4'd0);

        // R3 table walk: one event per vector
        foreach (VEC[k]) begin
            @(negedge clk);
            int_en = VEC[k][23];
            route  = VEC[k][17:9];
            drive_ev(VEC[k][8:0]);
            step();
            expect_out("R3", VEC[k][22], !VEC[k][22], VEC[k][22], VEC[k][21:18]);
            @(negedge clk); drive_ev('0);
            if (VEC[k][22]) exit_debug("R7");
        end

        // R5 R10 priority: bits 0,1,5 together, all to interrupt
        @(negedge clk); route = '0; int_en = 1'b1; drive_ev(9'h023);
        step(); expect_out("R5", 1'b0, 1'b1, 1'b0, 4'd0);
        @(negedge clk); drive_ev('0);
        step(); expect_out("R5", 1'b0, 1'b1, 1'b0, 4'd1);
        step(); expect_out("R5", 1'b0, 1'b1, 1'b0, 4'd5);
        step(); expect_out("R10", 1'b0, 1'b0, 1'b0, 4'd0);

        // R4 masked request held until int_en rises
        @(negedge clk); int_en = 1'b0; drive_ev(9'h010);
        step(); expect_out("R4", 1'b0, 1'b0, 1'b0, 4'd0);
        @(negedge clk); drive_ev('0);
        step(); expect_out("R4", 1'b0, 1'b0, 1'b0, 4'd0);
        @(negedge clk); int_en = 1'b1;
        step(); expect_out("R4", 1'b0, 1'b1, 1'b0, 4'd4);
        step(); expect_out("R10", 1'b0, 1'b0, 1'b0, 4'd0);

        // R9 event during debug is held, taken after exit
        @(negedge clk); route = 9'h004; drive_ev(9'h004);
        step(); expect_out("R6", 1'b1, 1'b0, 1'b1, 4'd2);
        @(negedge clk); drive_ev(9'h020);
        step(); expect_out("R9", 1'b1, 1'b0, 1'b0, 4'd0);
        @(negedge clk); drive_ev('0);
        step(); expect_out("R9", 1'b1, 1'b0, 1'b0, 4'd0);
        exit_debug("R7");
        #1; expect_out("R9", 1'b0, 1'b0, 1'b0, 4'd0);
        step(); expect_out("R9", 1'b0, 1'b1, 1'b0, 4'd5);

        // R7 rfi in RUN ignored
        @(negedge clk); rfi = 1'b1;
        step(); expect_out("R7", 1'b0, 1'b0, 1'b0, 4'd0);
        @(negedge clk); rfi = 1'b0;

        // R2 R1 R8 disabled strap: boot ignored, strap change later ignored
        do_reset(1'b0, 1'b1);
        expect_out("R8", 1'b0, 1'b0, 1'b0, 4'd0);
        @(negedge clk); strap = 1'b1; route = '1; drive_ev(9'h001);
        step(); expect_out("R2", 1'b0, 1'b1, 1'b0, 4'd0);
        @(negedge clk); drive_ev(9'h100);
        step(); expect_out("R1", 1'b0, 1'b1, 1'b0, 4'd8);
        @(negedge clk); drive_ev('0);

        // R8 R1 boot into debug, strap drop after reset ignored
        do_reset(1'b1, 1'b1);
        expect_out("R8", 1'b1, 1'b0, 1'b0, 4'd0);
        exit_debug("R7");
        strap = 1'b0; route = 9'h001; drive_ev(9'h001);
        step(); expect_out("R1", 1'b1, 1'b0, 1'b1, 4'd0);
        @(negedge clk); drive_ev('0);
        step(); expect_out("R10", 1'b1, 1'b0, 1'b0, 4'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule